// File: doc/BRIEF.md
# Half-to-Single Precision Widening Unpacker

This block takes one 128-bit vector operand, picks out a group of half-precision lanes from it, and widens each lane to single precision. The widening only moves bits. It unpacks sign, exponent and fraction and packs them again in the wider layout. It performs no arithmetic rounding and raises no exception flags. Infinities pass through unchanged. NaN payloads, including the quiet bit, are copied verbatim, so a signalling NaN is still signalling on the output. A downstream NaN-priority stage can therefore still tell it apart from a quiet one.

Two mode bits choose the source slice. A quad flag selects between four lanes taken from a 64-bit half of the vector and two lanes taken from a 32-bit word. An upper flag selects which half or word is used. Subnormal halves become normal singles through a leading-zero count, unless the flush-to-zero input is set. In that case they become a zero that keeps the input sign. A per-lane mask marks the outputs that carry data. A parameter either adds one register stage behind the converters, which updates on an input strobe, or leaves the path combinational.

Top module: `h2s_widen_unpack`

## Requirements
- R1: Lane fields are sign [15], exponent [14:10] and fraction [9:0]. The output uses sign [31], exponent [30:23] and fraction [22:0]. For a half exponent from 1 to 30, the sign is copied, the exponent becomes the input exponent plus 112, and the fraction is shifted left by 13 bits.
- R2: A half exponent of 5'h1F gives a single exponent of 8'hFF. The sign is copied, output fraction [22:13] equals the input fraction, and [12:0] is zero. Bit 22 is therefore never forced on, and a signalling NaN stays signalling.
- R3: A half with exponent 0 and fraction 0 gives a single that is zero in bits [30:0] and carries the input sign in bit 31.
- R4: With flush-to-zero low, a half with exponent 0 and a nonzero fraction gives a normal single. Let z be the number of leading zeros of the 10-bit fraction. The fraction is shifted left by z+1, its leading one is dropped, and the 10-bit result sits in [22:13]. The exponent is 112 - z.
- R5: With flush-to-zero high, every subnormal half gives a signed zero. Flush-to-zero has no effect on normal, zero, infinite or NaN lanes.
- R6: In quad mode, upper low selects vector bits [63:0] and upper high selects bits [127:64]. Output lane i converts bits [16i+15:16i] of that slice.
- R7: In non-quad mode, upper low selects vector bits [31:0] and upper high selects bits [63:32]. Lanes 0 and 1 come from that word, and output lanes 2 and 3 are zero.
- R8: For an accepted input, the lane mask is 4'b1111 in quad mode and 4'b0011 in non-quad mode.
- R9: With the output register enabled, out_valid follows in_valid one cycle later. Lane data and the mask load one cycle after a strobe and hold while in_valid is low. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input strobe; loads the output stage |
| vec_in | input | 128 | Source vector holding half-precision lanes |
| quad_mode | input | 1 | 1: four lanes from a 64-bit half; 0: two lanes from a 32-bit word |
| upper_sel | input | 1 | Selects the upper half (quad) or the upper word of the low half (non-quad) |
| ftz_en | input | 1 | Flush subnormal halves to signed zero |
| out_valid | output | 1 | Output strobe |
| lane_valid | output | 4 | Per-lane mask of meaningful outputs |
| lane_out | output | 128 | Widened single-precision lanes, lane i at [32i+31:32i] |

## Verification
Inputs are driven on the falling edge. With the default register stage, every result lands on the rising edge that follows a strobe: out_valid, the mask and all four lane words. The bench's behavioural model updates on that same rising edge, and the design is compared with it on the falling edge that comes after. Each comparison therefore looks at a result exactly one cycle after its stimulus. Idle cycles change vec_in with the strobe low, which exercises the hold behaviour. All 65,536 half encodings are swept through quad mode with flush-to-zero off and then on. Non-quad patterns then check the word selection and the zeroed upper lanes.

// File: rtl/h2s_pkg.sv
package h2s_pkg;
   localparam int HALF_W     = 16;
   localparam int SGL_W      = 32;
   localparam int H_EXP_W    = 5;
   localparam int H_FRAC_W   = 10;
   localparam int S_EXP_W    = 8;
   localparam int S_FRAC_W   = 23;
   localparam int BIAS_DIFF  = 127 - 15;
   localparam int FRAC_SHIFT = S_FRAC_W - H_FRAC_W;

   typedef logic [HALF_W-1:0] half_t;
   typedef logic [SGL_W-1:0]  sgl_t;
endpackage

// File: rtl/h2s_slice_pick.sv
module h2s_slice_pick
   import h2s_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int LANES = 4
) (
   input  logic [VEC_W-1:0]             vec_i,
   input  logic                         quad_i,
   input  logic                         upper_i,
   output logic [LANES-1:0][HALF_W-1:0] lanes_o,
   output logic [LANES-1:0]             mask_o
);
   localparam int SLICE_W  = LANES * HALF_W;
   localparam int NARROW_W = SLICE_W / 2;
   localparam int NLANES   = LANES / 2;

   if (VEC_W != 2 * SLICE_W) begin : g_bad_width
      $error("h2s_slice_pick: VEC_W must equal two lane slices");
   end
   if (LANES % 2 != 0) begin : g_bad_lanes
      $error("h2s_slice_pick: LANES must be even");
   end

   logic [SLICE_W-1:0]  wide_slice;
   logic [NARROW_W-1:0] narrow_slice;
   logic [SLICE_W-1:0]  chosen;

   assign wide_slice   = upper_i ? vec_i[VEC_W-1:SLICE_W] : vec_i[SLICE_W-1:0];
   assign narrow_slice = upper_i ? vec_i[SLICE_W-1:NARROW_W] : vec_i[NARROW_W-1:0];
   assign chosen       = quad_i ? wide_slice : {{NARROW_W{1'b0}}, narrow_slice};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes_o[g] = chosen[g*HALF_W +: HALF_W];
      if (g < NLANES) begin : g_low
         assign mask_o[g] = 1'b1;
      end else begin : g_high
         assign mask_o[g] = quad_i;
      end
   end
endmodule

// File: rtl/h2s_half2single.sv
module h2s_half2single
   import h2s_pkg::*;
(
   input  logic [HALF_W-1:0] half_i,
   input  logic              ftz_i,
   output logic [SGL_W-1:0]  sgl_o
);
   logic                sgn;
   logic [H_EXP_W-1:0]  hexp;
   logic [H_FRAC_W-1:0] hfrac;
   logic [3:0]          lz;
   logic                seen;
   logic [H_FRAC_W:0]   shifted;
   logic [S_EXP_W-1:0]  sexp;
   logic [H_FRAC_W-1:0] sfrac;

   assign sgn   = half_i[HALF_W-1];
   assign hexp  = half_i[HALF_W-2:H_FRAC_W];
   assign hfrac = half_i[H_FRAC_W-1:0];

   // leading-zero count over the 10-bit fraction
   always_comb begin
      lz   = 4'd0;
      seen = 1'b0;
      for (int i = H_FRAC_W - 1; i >= 0; i--) begin
         if (!seen && hfrac[i]) begin
            lz   = 4'(H_FRAC_W - 1 - i);
            seen = 1'b1;
         end
      end
   end

   assign shifted = {1'b0, hfrac} << (lz + 4'd1);

   always_comb begin
      sexp  = '0;
      sfrac = '0;
      if (hexp == '1) begin
         sexp  = '1;
         sfrac = hfrac;
      end else if (hexp == '0) begin
         if (hfrac != '0 && !ftz_i) begin
            sexp  = 8'(BIAS_DIFF) - {4'd0, lz};
            sfrac = shifted[H_FRAC_W-1:0];
         end
      end else begin
         sexp  = {3'd0, hexp} + 8'(BIAS_DIFF);
         sfrac = hfrac;
      end
   end

   assign sgl_o = {sgn, sexp, sfrac, {FRAC_SHIFT{1'b0}}};
endmodule

// File: rtl/h2s_out_stage.sv
module h2s_out_stage
   import h2s_pkg::*;
#(
   parameter int LANES   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic [LANES-1:0]        mask_i,
   input  logic [LANES*SGL_W-1:0]  data_i,
   output logic                    valid_o,
   output logic [LANES-1:0]        mask_o,
   output logic [LANES*SGL_W-1:0]  data_o
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_o <= 1'b0;
            mask_o  <= '0;
            data_o  <= '0;
         end else begin
            valid_o <= valid_i;
            if (valid_i) begin
               mask_o <= mask_i;
               data_o <= data_i;
            end
         end
      end

      assert_valid_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> valid_o);
      assert_idle_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> !valid_o);
      assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> ($stable(data_o) && $stable(mask_o)));
   end else begin : g_comb
      assign valid_o = valid_i;
      assign mask_o  = valid_i ? mask_i : '0;
      assign data_o  = data_i;
   end
endmodule

// File: rtl/h2s_widen_unpack.sv
module h2s_widen_unpack
   import h2s_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter int LANES   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [VEC_W-1:0]       vec_in,
   input  logic                   quad_mode,
   input  logic                   upper_sel,
   input  logic                   ftz_en,
   output logic                   out_valid,
   output logic [LANES-1:0]       lane_valid,
   output logic [LANES*SGL_W-1:0] lane_out
);
   localparam int NLANES = LANES / 2;

   logic [LANES-1:0][HALF_W-1:0] sel_lanes;
   logic [LANES-1:0]             sel_mask;
   logic [LANES*SGL_W-1:0]       cvt_bus;

   h2s_slice_pick #(.VEC_W(VEC_W), .LANES(LANES)) pick_i (
      .vec_i   (vec_in),
      .quad_i  (quad_mode),
      .upper_i (upper_sel),
      .lanes_o (sel_lanes),
      .mask_o  (sel_mask)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_cvt
      h2s_half2single cvt_i (
         .half_i (sel_lanes[g]),
         .ftz_i  (ftz_en),
         .sgl_o  (cvt_bus[g*SGL_W +: SGL_W])
      );

      assert_special_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_lanes[g][14:10] == 5'h1F) |->
         (cvt_bus[g*SGL_W+23 +: 8] == 8'hFF &&
          cvt_bus[g*SGL_W+13 +: 10] == sel_lanes[g][9:0] &&
          cvt_bus[g*SGL_W +: 13] == 13'd0 &&
          cvt_bus[g*SGL_W+31] == sel_lanes[g][15]));

      assert_normal_exp_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_lanes[g][14:10] != 5'h00 && sel_lanes[g][14:10] != 5'h1F) |->
         (cvt_bus[g*SGL_W+23 +: 8] == {3'd0, sel_lanes[g][14:10]} + 8'd112));

      assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (ftz_en && sel_lanes[g][14:10] == 5'h00) |->
         (cvt_bus[g*SGL_W +: 31] == 31'd0 &&
          cvt_bus[g*SGL_W+31] == sel_lanes[g][15]));

      assert_sub_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!ftz_en && sel_lanes[g][14:10] == 5'h00 && sel_lanes[g][9:0] != 10'd0) |->
         (cvt_bus[g*SGL_W+23 +: 8] <= 8'd112 && cvt_bus[g*SGL_W+23 +: 8] >= 8'd103));

      if (g >= NLANES) begin : g_hi
         assert_narrow_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !quad_mode |-> (cvt_bus[g*SGL_W +: SGL_W] == '0 && !sel_mask[g]));
      end
   end

   assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sel_mask) == (quad_mode ? LANES : NLANES));

   h2s_out_stage #(.LANES(LANES), .REG_OUT(REG_OUT)) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_i (in_valid),
      .mask_i  (sel_mask),
      .data_i  (cvt_bus),
      .valid_o (out_valid),
      .mask_o  (lane_valid),
      .data_o  (lane_out)
   );
endmodule

// File: tb/h2s_widen_unpack_tb.sv
`timescale 1ns/1ps
module h2s_widen_unpack_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] vec_in = '0;
   logic         quad_mode = 1'b0;
   logic         upper_sel = 1'b0;
   logic         ftz_en = 1'b0;
   logic         out_valid;
   logic [3:0]   lane_valid;
   logic [127:0] lane_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   h2s_widen_unpack dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_in(vec_in),
      .quad_mode(quad_mode), .upper_sel(upper_sel), .ftz_en(ftz_en),
      .out_valid(out_valid), .lane_valid(lane_valid), .lane_out(lane_out)
   );

   // behavioural reference conversion
   function automatic logic [31:0] ref_cvt(input logic [15:0] h, input bit ftz);
      int s, e, f, e32;
      s = h[15]; e = h[14:10]; f = h[9:0];
      if (e == 31) return {h[15], 8'hFF, h[9:0], 13'd0};
      if (e == 0) begin
         if (f == 0 || ftz) return {h[15], 31'd0};
         e32 = 113;
         while ((f & 'h400) == 0) begin
            f = f * 2;
            e32 = e32 - 1;
         end
         return {h[15], 8'(e32), 10'(f), 13'd0};
      end
      return {h[15], 8'(e + 112), h[9:0], 13'd0};
   endfunction

   // model state, updated on the same edge as the design
   logic         m_valid;
   logic [3:0]   m_mask;
   logic [127:0] m_out;
   logic [15:0]  m_src [4];
   bit           m_quad, m_ftz;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0; m_mask <= '0; m_out <= '0;
         m_quad <= 1'b0; m_ftz <= 1'b0;
         for (int i = 0; i < 4; i++) m_src[i] <= '0;
      end else begin
         m_valid <= in_valid;
         if (in_valid) begin
            logic [15:0] hs [4];
            for (int i = 0; i < 4; i++) begin
               if (quad_mode) hs[i] = upper_sel ? vec_in[64 + 16*i +: 16] : vec_in[16*i +: 16];
               else if (i < 2) hs[i] = upper_sel ? vec_in[32 + 16*i +: 16] : vec_in[16*i +: 16];
               else hs[i] = 16'd0;
               m_src[i] <= hs[i];
               m_out[32*i +: 32] <= (quad_mode || i < 2) ? ref_cvt(hs[i], ftz_en) : 32'd0;
            end
            m_mask <= quad_mode ? 4'b1111 : 4'b0011;
            m_quad <= quad_mode;
            m_ftz  <= ftz_en;
         end
      end
   end

   function automatic string req_of(input logic [15:0] h, input bit ftz, input bit q, input int lane);
      if (!q && lane >= 2) return "R7";
      if (h[14:10] == 5'h1F) return "R2";
      if (h[14:10] == 5'h00 && h[9:0] == 10'd0) return "R3";
      if (h[14:10] == 5'h00) return ftz ? "R5" : "R4";
      return "R1";
   endfunction

   // per-clock comparison on the falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         tests++;
         if (out_valid !== m_valid) begin
            fails++;
            $display("FAIL R9 out_valid actual %b expected %b", out_valid, m_valid);
         end
         tests++;
         if (lane_valid !== m_mask) begin
            fails++;
            $display("FAIL R8 lane mask actual %b expected %b", lane_valid, m_mask);
         end
         for (int i = 0; i < 4; i++) begin
            tests++;
            if (lane_out[32*i +: 32] !== m_out[32*i +: 32]) begin
               fails++;
               $display("FAIL %s (slice %s) lane %0d src %h actual %h expected %h",
                        req_of(m_src[i], m_ftz, m_quad, i), m_quad ? "R6" : "R7",
                        i, m_src[i], lane_out[32*i +: 32], m_out[32*i +: 32]);
            end
         end
      end
   end

   task automatic drive(input logic [127:0] v, input bit q, input bit u, input bit f, input bit val);
      @(negedge clk);
      vec_in = v; quad_mode = q; upper_sel = u; ftz_en = f; in_valid = val;
   endtask

   task automatic summary();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog actual %0d cycles expected fewer", 190000);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R9)
      tests++;
      if (out_valid !== 1'b0 || lane_valid !== 4'd0 || lane_out !== '0) begin
         fails++;
         $display("FAIL R9 reset actual %b/%b/%h expected 0/0/0", out_valid, lane_valid, lane_out);
      end
      @(negedge clk); rst_n = 1'b1;

      // exhaustive quad sweep, both ftz settings (R1-R6 via model)
      for (int f = 0; f < 2; f++) begin
         for (int k = 0; k < 16384; k++) begin
            logic [63:0]  lanes, junk;
            logic [127:0] v;
            bit u;
            lanes = {16'(4*k+3), 16'(4*k+2), 16'(4*k+1), 16'(4*k)};
            junk  = 64'hA5A5_7C01_FC00_5A5A ^ 64'(k);
            u = k[0];
            v = u ? {lanes, junk} : {junk, lanes};
            drive(v, 1'b1, u, f[0], 1'b1);
         end
      end

      // idle with changing input: outputs hold (R9)
      drive({4{32'h7E00_8001}}, 1'b1, 1'b0, 1'b0, 1'b0);
      drive({4{32'h0001_FC01}}, 1'b0, 1'b1, 1'b1, 1'b0);

      // non-quad word selection and zeroed upper lanes (R7, R8)
      drive(128'hFFFF_FFFF_FFFF_FFFF_1234_5678_7D00_0001, 1'b0, 1'b0, 1'b0, 1'b1);
      drive(128'hFFFF_FFFF_FFFF_FFFF_8200_3C00_7D00_0001, 1'b0, 1'b1, 1'b0, 1'b1);
      drive(128'hFFFF_FFFF_FFFF_FFFF_8200_3C00_7D00_0001, 1'b0, 1'b1, 1'b1, 1'b1);
      drive(128'h7C01_7E00_0000_8000_03FF_8001_7C00_FC00, 1'b0, 1'b0, 1'b1, 1'b1);
      // signalling NaN in quad upper half (R2, R6)
      drive(128'h7C01_FD55_0200_8000_1111_2222_3333_4444, 1'b1, 1'b1, 1'b0, 1'b1);
      drive(128'h0, 1'b1, 1'b0, 1'b0, 1'b0);
      drive(128'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      summary();
   end
endmodule